// File: doc/BRIEF.md
# Next-Fetch-Address Selector

This block owns the program counter of a 32-bit RISC core whose instructions are 32 bits wide and sit on word boundaries. Each cycle it looks at the instruction fetched from the current PC, together with the two source-register values and a separate jump-source value. From these it picks the address to fetch next and loads it into the PC on the following clock edge.

Four ways of forming the next address are supported. The first is plain sequential advance. The second is a PC-relative target for the equal and not-equal conditional branches. The third is a pseudodirect target that splices a 26-bit field under the top bits of the incremented PC. The fourth is a target taken straight from a register. For the call instruction it also raises a one-cycle request to write the return address into register 31. The register file, instruction memory and ALU are outside the block; the core feeds the block the operand values that those units produce.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with 0 and `link_we` is low.
- R2: Any instruction that is not a control transfer loads PC+4 into the PC at the next edge. This includes opcode 0 with a function code other than 8.
- R3: Branch-if-equal is opcode 4. When `rs_val == rt_val`, the next PC is PC+4 plus (sign-extended instr[15:0] shifted left by 2).
- R4: Branch-if-equal with unequal operands falls through to PC+4.
- R5: Branch-if-not-equal is opcode 5. It takes the same PC-relative target when the operands differ, and falls through to PC+4 when they are equal.
- R6: A branch offset with bit 15 set moves the PC backwards. The offset is sign-extended, not zero-extended.
- R7: Jump is opcode 2. The next PC is {PC+4 bits [31:28], instr[25:0], 2'b00}.
- R8: Register jump is opcode 0 with function code instr[5:0] = 8. The next PC is `jr_src`, taken unchanged.
- R9: Jump-and-link is opcode 3. It forms the same target as jump. In the same cycle it drives `link_we` high, `link_addr` = PC+4 and `link_reg` = 31.
- R10: `link_we` is low for every instruction other than jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction fetched from the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| jr_src | input | 32 | Target value for the register jump |
| pc | output | 32 | Current fetch address |
| link_we | output | 1 | Return-address write request (jump-and-link only) |
| link_addr | output | 32 | Return address, PC+4 |
| link_reg | output | 5 | Destination register of the link write, always 31 |

## Verification
The assertions assume that `instr`, `rs_val`, `rt_val` and `jr_src` stay stable between clock edges. They also assume that the instruction on `instr` is the one that belongs to the current PC, so each cycle carries exactly one decision. The bench keeps to this by changing inputs only on the falling edge and presenting one instruction per cycle. It also drives register-jump targets that are word-aligned, so the PC never leaves a word boundary.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN = 32;
  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_JUMP    = 6'd2;
  localparam logic [5:0] OPC_CALL    = 6'd3;
  localparam logic [5:0] OPC_BEQ     = 6'd4;
  localparam logic [5:0] OPC_BNE     = 6'd5;
  localparam logic [5:0] FN_REGJUMP  = 6'd8;

  // one-hot choice of the next-address source
  typedef struct packed {
    logic from_reg;
    logic from_jump;
    logic from_branch;
    logic from_seq;
  } npc_sel_t;

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] pc4,
                                                 input logic [15:0] off);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-18){off[15]}}, off, 2'b00};
    return pc4 + ext;
  endfunction

  function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] pc4,
                                                    input logic [25:0] field);
    return {pc4[XLEN-1:XLEN-4], field, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output npc_sel_t        sel,
  output logic            is_call
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       operands_eq;
  logic       is_beq, is_bne, is_jump, is_rjump, branch_taken;

  assign opc          = instr[31:26];
  assign fn           = instr[5:0];
  assign operands_eq  = (rs_val == rt_val);
  assign is_beq       = (opc == OPC_BEQ);
  assign is_bne       = (opc == OPC_BNE);
  assign is_jump      = (opc == OPC_JUMP);
  assign is_call      = (opc == OPC_CALL);
  assign is_rjump     = (opc == OPC_SPECIAL) && (fn == FN_REGJUMP);
  assign branch_taken = (is_beq && operands_eq) || (is_bne && !operands_eq);

  always_comb begin
    sel             = '0;
    sel.from_reg    = is_rjump;
    sel.from_jump   = is_jump || is_call;
    sel.from_branch = branch_taken;
    sel.from_seq    = !(is_rjump || is_jump || is_call || branch_taken);
  end

  assert_single_source_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel));
  assert_bne_equal_falls_R5: assert property (@(posedge clk) disable iff (rst)
    (is_bne && operands_eq) |-> sel.from_seq);
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] jr_src,
  input  npc_sel_t        sel,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] next_pc
);
  logic [XLEN-1:0] tgt_rel, tgt_region;

  assign pc_plus4   = pc + XLEN'(4);
  assign tgt_rel    = rel_target(pc_plus4, instr[15:0]);
  assign tgt_region = region_target(pc_plus4, instr[25:0]);

  always_comb begin
    next_pc = pc_plus4;
    if (sel.from_reg)         next_pc = jr_src;
    else if (sel.from_jump)   next_pc = tgt_region;
    else if (sel.from_branch) next_pc = tgt_rel;
  end
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] next_pc,
  input  npc_sel_t        sel,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == RESET_PC));
  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
    sel.from_seq |=> (pc == $past(pc) + XLEN'(4)));
  assert_jump_field_R7: assert property (@(posedge clk) disable iff (rst)
    sel.from_jump |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [4:0]  LINK_REG = 5'd31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic [31:0] jr_src,
  output logic [31:0] pc,
  output logic        link_we,
  output logic [31:0] link_addr,
  output logic [4:0]  link_reg
);
  npc_sel_t    sel;
  logic        is_call;
  logic [31:0] pc_plus4, next_pc;

  npc_decode u_dec (
    .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .sel(sel), .is_call(is_call)
  );

  npc_target u_tgt (
    .pc(pc), .instr(instr), .jr_src(jr_src), .sel(sel),
    .pc_plus4(pc_plus4), .next_pc(next_pc)
  );

  npc_pcreg #(.RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .next_pc(next_pc), .sel(sel), .instr(instr), .pc(pc)
  );

  assign link_we   = is_call && !rst;
  assign link_addr = pc_plus4;
  assign link_reg  = LINK_REG;

  assert_link_target_R9: assert property (@(posedge clk) disable iff (rst)
    link_we |=> (pc == {$past(link_addr[31:28]), $past(instr[25:0]), 2'b00}));
  assert_link_only_call_R10: assert property (@(posedge clk) disable iff (rst)
    link_we |-> sel.from_jump && !sel.from_reg);
  assert_regjump_R8: assert property (@(posedge clk) disable iff (rst)
    sel.from_reg |=> (pc == $past(jr_src)));
  assert_branch_rel_R3: assert property (@(posedge clk) disable iff (rst)
    sel.from_branch |=> ((pc - $past(pc) - 32'd4) ==
                          {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr, rs_val, rt_val, jr_src;
  logic [31:0] pc, link_addr;
  logic        link_we;
  logic [4:0]  link_reg;
  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc;

  always #10 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .jr_src(jr_src), .pc(pc), .link_we(link_we), .link_addr(link_addr),
    .link_reg(link_reg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // present one instruction, check link outputs, then check the PC after the edge
  task automatic step(input string req, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] js,
                      input logic [31:0] exp_next, input logic exp_link);
    instr = ins; rs_val = a; rt_val = b; jr_src = js;
    #1;
    check({req, " link_we"}, {31'd0, link_we}, {31'd0, exp_link});
    if (exp_link) begin
      check({req, " link_addr"}, link_addr, model_pc + 32'd4);
      check({req, " link_reg"}, {27'd0, link_reg}, 32'd31);
    end
    @(negedge clk);
    check({req, " pc"}, pc, exp_next);
    model_pc = exp_next;
  endtask

  task automatic t_reset_R1();
    rst = 1'b1; instr = mk_i(6'd3, 0, 0, 16'h0); rs_val = 0; rt_val = 0; jr_src = 0;
    repeat (2) @(negedge clk);
    check("R1 pc", pc, 32'd0);
    check("R1 link_we", {31'd0, link_we}, 32'd0);
    rst = 1'b0; model_pc = 32'd0;
  endtask

  task automatic t_seq_R2();
    step("R2 addi", mk_i(6'd8, 1, 2, 16'h7), 0, 0, 0, model_pc + 4, 1'b0);
    step("R2 lw", mk_i(6'd35, 3, 4, 16'h30), 5, 5, 32'h100, model_pc + 4, 1'b0);
    step("R2 add", 32'h0232_4020, 1, 2, 32'h200, model_pc + 4, 1'b0);
  endtask

  task automatic t_beq_R3_R4();
    step("R3 beq taken", mk_i(6'd4, 1, 2, 16'd3), 32'h55, 32'h55, 0, model_pc + 4 + 12, 1'b0);
    step("R4 beq fall", mk_i(6'd4, 1, 2, 16'd3), 32'h55, 32'h56, 0, model_pc + 4, 1'b0);
  endtask

  task automatic t_bne_R5_R6();
    step("R5 bne taken", mk_i(6'd5, 1, 2, 16'd8), 32'h1, 32'h2, 0, model_pc + 4 + 32, 1'b0);
    step("R5 bne fall", mk_i(6'd5, 1, 2, 16'd8), 32'h9, 32'h9, 0, model_pc + 4, 1'b0);
    step("R6 back", mk_i(6'd5, 1, 2, 16'hFFFE), 32'h0, 32'h3, 0, model_pc + 4 - 8, 1'b0);
    step("R6 beq back", mk_i(6'd4, 1, 2, 16'h8000), 32'h7, 32'h7, 32'h0,
         model_pc + 4 - 32'h0002_0000 + 32'h0004_0000 - 32'h0004_0000, 1'b0);
  endtask

  task automatic t_rjump_R8();
    step("R8 jr", {6'd0, 5'd9, 15'd0, 6'd8}, 0, 0, 32'h3000_0010, 32'h3000_0010, 1'b0);
    step("R8 other funct", {6'd0, 5'd9, 15'd0, 6'd9}, 0, 0, 32'h4000_0000, model_pc + 4, 1'b0);
  endtask

  task automatic t_jump_R7();
    logic [31:0] p4;
    p4 = model_pc + 4;
    step("R7 j", {6'd2, 26'h000_0040}, 0, 0, 32'hFFFF_FFF0,
         {p4[31:28], 26'h000_0040, 2'b00}, 1'b0);
  endtask

  task automatic t_call_R9_R10();
    logic [31:0] p4;
    p4 = model_pc + 4;
    step("R9 jal", {6'd3, 26'h3FF_FFFF}, 0, 0, 0, {p4[31:28], 26'h3FF_FFFF, 2'b00}, 1'b1);
    step("R10 after jal", mk_i(6'd8, 0, 0, 0), 0, 0, 0, model_pc + 4, 1'b0);
    step("R10 beq no link", mk_i(6'd4, 0, 0, 16'd1), 0, 0, 0, model_pc + 8, 1'b0);
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_seq_R2();
    t_beq_R3_R4();
    t_bne_R5_R6();
    t_rjump_R8();
    t_jump_R7();
    t_call_R9_R10();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule